// File: doc/BRIEF.md
# Semaphore-Gated Packet Chain Sequencer

This block runs one channel of a packet processor. Software builds a linked list of work packets in memory, writes the address of the first packet into the command pointer, and adds a count of pending packets to an 8-bit semaphore. The channel then reads two words of each packet over a simple request/acknowledge read port. The first word is the address of the following packet and the second is the control word. The channel hands the control word to a processing engine and waits for the engine to report done or error.

Each time a packet finishes, the channel decides whether to go on to the next packet. It continues only when the packet's chain bit is set, the semaphore is non-zero after any decrement, and no error has been latched. When the engine reports an error, the channel latches a sticky error flag, zeroes the semaphore, raises its interrupt, and refuses to start any further packet until software acknowledges the error. Packets can also ask for an interrupt when they complete normally.

Register access uses a small write/read port with four addresses: command pointer (0), semaphore add (1), semaphore clear (2) and status (3).

Top module: `dcs_chain_ctrl`

## Requirements
- R1: After reset, every register read returns 0 and mem_req, eng_start and irq are low.
- R2: A write to address 1 adds wdata[7:0] to the semaphore and saturates at 255. A non-zero add also arms the channel.
- R3: A write to address 2 clears every semaphore bit whose wdata bit is 1, so writing 0xFF zeroes the semaphore. This write never starts a packet.
- R4: An armed idle channel with a non-zero semaphore and no error reads word 0 at the command pointer, then word 1 at pointer+4. Each request stays asserted, with a stable address, until mem_ack.
- R5: After word 1 returns, eng_start pulses for one cycle with eng_ctrl equal to word 1. Packets are issued in list order.
- R6: On eng_done, a set control bit 1 (decrement) lowers the semaphore by one. A packet with bit 1 clear leaves the semaphore unchanged.
- R7: On eng_done, the command pointer takes the packet's word 0. If control bit 0 (chain) is set and the semaphore after any decrement is non-zero, the next packet is fetched from that address without software action.
- R8: After a packet whose chain bit is clear, the channel stops and disarms, even when the semaphore is non-zero. Only a later non-zero add starts it again.
- R9: When the semaphore reaches zero in the middle of a chain, the channel halts with the pointer on the next packet. It resumes from that packet once the semaphore is raised.
- R10: On eng_err, the semaphore is forced to 0, the sticky error flag (status bit 0) is set, irq pulses, and the pointer stays on the failing packet.
- R11: While the error flag is set, no packet starts, even if the semaphore is raised. Writing 1 to status bit 0 clears the flag, and the channel may then resume from the pointer.
- R12: On normal completion, irq pulses for one cycle only when control bit 2 (interrupt enable) of that packet is set.
- R13: Status bits [3:2] report the channel state: 0 idle, 1 fetching, 2 running, 3 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | DW | Memory read data |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_ctrl | output | DW | Control word of the current packet |
| eng_done | input | 1 | Engine finished the packet normally |
| eng_err | input | 1 | Engine finished the packet with an error |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench targets these corner cases:
- A chain that ends while the semaphore is still non-zero. A design that ignored the chain bit, or did not disarm, would loop back and fetch the following packet.
- A semaphore that runs out part-way through a chain. A design that tested the value before the decrement would run one packet too many, and a design that kept the wrong pointer would resume at the wrong packet.
- A semaphore raise while an error is pending. A design that did not hold the channel would start work before the acknowledge, and one that advanced the pointer on error would skip the failed packet on retry.
- Saturation and bit-wise clear of the semaphore, and suppression of the interrupt when a packet does not request it.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_NXT,
    S_FETCH_CTL,
    S_START,
    S_RUN,
    S_ERR
  } seq_state_e;

  // control word bit positions
  localparam int CTL_CHAIN = 0;
  localparam int CTL_DEC   = 1;
  localparam int CTL_IE    = 2;

  // register addresses
  localparam logic [1:0] RA_PTR     = 2'd0;
  localparam logic [1:0] RA_SEM_ADD = 2'd1;
  localparam logic [1:0] RA_SEM_CLR = 2'd2;
  localparam logic [1:0] RA_STATUS  = 2'd3;

  // status state codes
  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_FETCH = 2'd1;
  localparam logic [1:0] ST_RUN   = 2'd2;
  localparam logic [1:0] ST_ERR   = 2'd3;

  function automatic logic [1:0] state_code(seq_state_e s);
    case (s)
      S_FETCH_NXT, S_FETCH_CTL: state_code = ST_FETCH;
      S_START, S_RUN:           state_code = ST_RUN;
      S_ERR:                    state_code = ST_ERR;
      default:                  state_code = ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/dcs_rst_sync.sv
module dcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dcs_sem.sv
module dcs_sem #(
  parameter int SEMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            add_we,
  input  logic            clr_we,
  input  logic [SEMW-1:0] wval,
  input  logic            dec_req,
  input  logic            zero_req,
  output logic [SEMW-1:0] sem_q,
  output logic [SEMW-1:0] sem_d
);
  localparam logic [SEMW:0]   SUM_MAX = {1'b0, {SEMW{1'b1}}};
  localparam logic [SEMW-1:0] SEM_MAX = {SEMW{1'b1}};

  logic [SEMW-1:0] sem_r;
  logic [SEMW:0]   sum;
  logic [SEMW-1:0] v;
  logic            sem_en;

  // software clear, then saturating add, then hardware decrement; error zero wins
  always_comb begin
    v = sem_r;
    if (clr_we) v = v & ~wval;
    sum = {1'b0, v} + {1'b0, wval};
    if (add_we) v = (sum > SUM_MAX) ? SEM_MAX : sum[SEMW-1:0];
    if (dec_req && (v != '0)) v = v - SEMW'(1);
    if (zero_req) v = '0;
    sem_d = v;
  end

  assign sem_en = add_we | clr_we | dec_req | zero_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sem_r <= '0;
    else if (sem_en) sem_r <= sem_d;
  end

  assign sem_q = sem_r;

  p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q == SEM_MAX && add_we && !clr_we && !dec_req && !zero_req) |=> (sem_q == SEM_MAX));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !add_we && !dec_req && !zero_req) |=> ((sem_q & $past(wval)) == '0));

  p_dec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !add_we && !clr_we && !zero_req && sem_q != '0) |=> (sem_q == $past(sem_q) - SEMW'(1)));
endmodule

// File: rtl/dcs_stat.sv
module dcs_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic err_ev,
  input  logic done_irq_ev,
  input  logic ack_we,
  input  logic ack_bit,
  output logic err_q,
  output logic irq_q
);
  logic err_r, err_d, err_en;
  logic irq_r, irq_d;

  always_comb begin
    err_en = err_ev | (ack_we & ack_bit);
    err_d  = err_ev;          // a new error wins over an acknowledge
    irq_d  = err_ev | done_irq_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_r <= 1'b0;
      irq_r <= 1'b0;
    end else begin
      if (err_en) err_r <= err_d;
      irq_r <= irq_d;
    end
  end

  assign err_q = err_r;
  assign irq_q = irq_r;
endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
  import dcs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SEMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ptr_we,
  input  logic [AW-1:0]   ptr_wdata,
  input  logic            arm_set,
  input  logic [SEMW-1:0] sem_q,
  input  logic [SEMW-1:0] sem_d,
  input  logic            err_q,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  output logic            eng_start,
  output logic [DW-1:0]   eng_ctrl,
  input  logic            eng_done,
  input  logic            eng_err,
  output logic [AW-1:0]   ptr_q,
  output logic            dec_req,
  output logic            err_ev,
  output logic            done_irq_ev,
  output logic [1:0]      st_code
);
  localparam logic [AW-1:0] WORD_OFS = AW'(DW / 8);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] ptr_r, ptr_d;
  logic [AW-1:0] nxt_q, nxt_d;
  logic [DW-1:0] ctl_q, ctl_d;
  logic          armed_q, armed_d;
  logic          run_fin;

  assign run_fin     = (state_q == S_RUN) && eng_done && !eng_err;
  assign err_ev      = (state_q == S_RUN) && eng_err;
  assign dec_req     = run_fin && ctl_q[CTL_DEC];
  assign done_irq_ev = run_fin && ctl_q[CTL_IE];

  assign mem_req   = (state_q == S_FETCH_NXT) || (state_q == S_FETCH_CTL);
  assign mem_addr  = (state_q == S_FETCH_CTL) ? (ptr_r + WORD_OFS) : ptr_r;
  assign eng_start = (state_q == S_START);
  assign eng_ctrl  = ctl_q;
  assign ptr_q     = ptr_r;
  assign st_code   = state_code(state_q);

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_r;
    nxt_d   = nxt_q;
    ctl_d   = ctl_q;
    armed_d = armed_q;
    if (ptr_we) ptr_d = ptr_wdata;
    case (state_q)
      S_IDLE: begin
        if (armed_q && (sem_q != '0) && !err_q) state_d = S_FETCH_NXT;
      end
      S_FETCH_NXT: begin
        if (mem_ack) begin
          nxt_d   = mem_rdata[AW-1:0];
          state_d = S_FETCH_CTL;
        end
      end
      S_FETCH_CTL: begin
        if (mem_ack) begin
          ctl_d   = mem_rdata;
          state_d = S_START;
        end
      end
      S_START: state_d = S_RUN;
      S_RUN: begin
        if (eng_err) begin
          armed_d = 1'b0;
          state_d = S_ERR;
        end else if (eng_done) begin
          ptr_d = nxt_q;
          if (!ctl_q[CTL_CHAIN]) armed_d = 1'b0;
          if (ctl_q[CTL_CHAIN] && (sem_d != '0)) state_d = S_FETCH_NXT;
          else                                   state_d = S_IDLE;
        end
      end
      S_ERR: begin
        if (!err_q) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
    if (arm_set) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_r   <= '0;
      nxt_q   <= '0;
      ctl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_r   <= ptr_d;
      armed_q <= armed_d;
      if (state_q == S_FETCH_NXT) nxt_q <= nxt_d;
      if (state_q == S_FETCH_CTL) ctl_q <= ctl_d;
    end
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_chain_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_fin && !ctl_q[CTL_CHAIN]) |=> (st_code == ST_IDLE));

  p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == ST_IDLE && sem_q == '0) |=> (st_code == ST_IDLE));

  p_no_start_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !eng_start);
endmodule

// File: rtl/dcs_chain_ctrl.sv
module dcs_chain_ctrl
  import dcs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SEMW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          eng_start,
  output logic [DW-1:0] eng_ctrl,
  input  logic          eng_done,
  input  logic          eng_err,
  output logic          irq
);
  logic            rst_ni;
  logic            ptr_we, add_we, clr_we, ack_we, arm_set;
  logic [SEMW-1:0] wval, sem_q, sem_d;
  logic [AW-1:0]   ptr_q;
  logic            dec_req, err_ev, done_irq_ev, err_q;
  logic [1:0]      st_code;

  dcs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  assign wval    = reg_wdata[SEMW-1:0];
  assign ptr_we  = reg_we && (reg_addr == RA_PTR);
  assign add_we  = reg_we && (reg_addr == RA_SEM_ADD);
  assign clr_we  = reg_we && (reg_addr == RA_SEM_CLR);
  assign ack_we  = reg_we && (reg_addr == RA_STATUS);
  assign arm_set = add_we && (wval != '0);

  dcs_sem #(.SEMW(SEMW)) u_sem (
    .clk(clk), .rst_n(rst_ni),
    .add_we(add_we), .clr_we(clr_we), .wval(wval),
    .dec_req(dec_req), .zero_req(err_ev),
    .sem_q(sem_q), .sem_d(sem_d)
  );

  dcs_stat u_stat (
    .clk(clk), .rst_n(rst_ni),
    .err_ev(err_ev), .done_irq_ev(done_irq_ev),
    .ack_we(ack_we), .ack_bit(reg_wdata[0]),
    .err_q(err_q), .irq_q(irq)
  );

  dcs_seq #(.AW(AW), .DW(DW), .SEMW(SEMW)) u_seq (
    .clk(clk), .rst_n(rst_ni),
    .ptr_we(ptr_we), .ptr_wdata(reg_wdata[AW-1:0]), .arm_set(arm_set),
    .sem_q(sem_q), .sem_d(sem_d), .err_q(err_q),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .eng_start(eng_start), .eng_ctrl(eng_ctrl), .eng_done(eng_done), .eng_err(eng_err),
    .ptr_q(ptr_q), .dec_req(dec_req), .err_ev(err_ev), .done_irq_ev(done_irq_ev),
    .st_code(st_code)
  );

  always_comb begin
    case (reg_addr)
      RA_PTR:     reg_rdata = DW'(ptr_q);
      RA_SEM_ADD,
      RA_SEM_CLR: reg_rdata = DW'(sem_q);
      default:    reg_rdata = DW'({st_code, 1'b0, err_q});
    endcase
  end

  p_err_clears_sem_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    err_ev |=> (sem_q == '0 && err_q && irq));

  p_err_state_r13: assert property (@(posedge clk) disable iff (!rst_ni)
    err_q |-> (st_code == ST_ERR));
endmodule

// File: tb/dcs_chain_ctrl_test.sv
`timescale 1ns/1ps
module dcs_chain_ctrl_test;
  localparam logic [1:0] A_PTR = 2'd0, A_ADD = 2'd1, A_CLR = 2'd2, A_ST = 2'd3;
  localparam logic [31:0] F_CH = 32'h1, F_DEC = 32'h2, F_IE = 32'h4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        eng_start, eng_done, eng_err, irq;
  logic [31:0] eng_ctrl;

  logic [31:0] mem [0:1023];
  logic [31:0] flog [0:63];
  logic [31:0] clog [0:63];
  int fcnt, scnt, irq_cnt, cur_idx, err_idx;
  logic [3:0] ecnt;
  int nchecks = 0, nfail = 0;

  always #2.5 clk = ~clk;

  dcs_chain_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .eng_start(eng_start), .eng_ctrl(eng_ctrl), .eng_done(eng_done), .eng_err(eng_err),
    .irq(irq)
  );

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; fcnt <= 0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem[mem_addr[11:2]];
      if (mem_req && mem_ack) begin
        if (fcnt < 64) flog[fcnt] <= mem_addr;
        fcnt <= fcnt + 1;
      end
    end
  end

  // engine model: finishes three cycles after start
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_done <= 1'b0; eng_err <= 1'b0; ecnt <= '0; scnt <= 0; cur_idx <= 0; irq_cnt <= 0;
    end else begin
      eng_done <= 1'b0; eng_err <= 1'b0;
      if (irq) irq_cnt <= irq_cnt + 1;
      if (eng_start) begin
        if (scnt < 64) clog[scnt] <= eng_ctrl;
        cur_idx <= scnt;
        scnt    <= scnt + 1;
        ecnt    <= 4'd3;
      end else if (ecnt != 0) begin
        ecnt <= ecnt - 4'd1;
        if (ecnt == 4'd1) begin
          if (cur_idx == err_idx) eng_err <= 1'b1;
          else                    eng_done <= 1'b1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchecks++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_quiet();
    logic [31:0] s;
    int quiet = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(A_ST, s);
      if (s[3:2] == 2'd0 || s[3:2] == 2'd3) quiet++; else quiet = 0;
      if (quiet >= 8) break;
    end
  endtask

  task automatic put_pkt(input int addr, input logic [31:0] nxt, input logic [31:0] ctl);
    mem[addr >> 2]       = nxt;
    mem[(addr >> 2) + 1] = ctl;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_PTR, d); chk("R1", "pointer after reset", d, 0);
    rd(A_ADD, d); chk("R1", "semaphore after reset", d, 0);
    rd(A_ST, d);  chk("R1", "status after reset", d, 0);
    chk("R1", "mem_req after reset", mem_req, 0);
    chk("R1", "eng_start/irq after reset", {eng_start, irq}, 0);
  endtask

  task automatic t_sem_regs();
    logic [31:0] d;
    wr(A_ADD, 32'd5);   wait_quiet(); rd(A_ADD, d); chk("R2", "add 5", d, 5);
    wr(A_ADD, 32'd200); wait_quiet(); rd(A_ADD, d); chk("R2", "add 200", d, 205);
    wr(A_ADD, 32'd100); wait_quiet(); rd(A_ADD, d); chk("R2", "saturate at 255", d, 255);
    wr(A_CLR, 32'h0F);  rd(A_CLR, d); chk("R3", "clear low nibble", d, 32'hF0);
    wr(A_CLR, 32'hFF);  rd(A_CLR, d); chk("R3", "clear all", d, 0);
  endtask

  task automatic t_full_dec();
    logic [31:0] d;
    int s0 = scnt, f0 = fcnt, i0 = irq_cnt;
    put_pkt(32'h100, 32'h140, F_CH | F_DEC | 32'h1100);
    put_pkt(32'h140, 32'h180, F_CH | F_DEC | 32'h2200);
    put_pkt(32'h180, 32'h1C0, F_DEC | 32'h3300);
    wr(A_PTR, 32'h100);
    wr(A_ADD, 32'd3);
    rd(A_ST, d); chk("R13", "state fetching after start", d[3:2], 1);
    wait_quiet();
    chk("R7", "packets run in chain", scnt - s0, 3);
    chk("R4", "word0 addr pkt0", flog[f0], 32'h100);
    chk("R4", "word1 addr pkt0", flog[f0+1], 32'h104);
    chk("R7", "word0 addr pkt1", flog[f0+2], 32'h140);
    chk("R7", "word0 addr pkt2", flog[f0+4], 32'h180);
    chk("R5", "ctrl pkt0", clog[s0], F_CH | F_DEC | 32'h1100);
    chk("R5", "ctrl pkt2", clog[s0+2], F_DEC | 32'h3300);
    rd(A_ADD, d); chk("R6", "sem after three decrements", d, 0);
    rd(A_PTR, d); chk("R7", "pointer after chain", d, 32'h1C0);
    rd(A_ST, d);  chk("R13", "idle status", d, 0);
    chk("R12", "no irq without enable", irq_cnt - i0, 0);
  endtask

  task automatic t_last_dec();
    logic [31:0] d;
    int s0 = scnt;
    put_pkt(32'h200, 32'h240, F_CH);
    put_pkt(32'h240, 32'h280, F_CH);
    put_pkt(32'h280, 32'h2C0, F_DEC);
    wr(A_PTR, 32'h200);
    wr(A_ADD, 32'd1);
    wait_quiet();
    chk("R6", "non-decrementing packets keep semaphore", scnt - s0, 3);
    rd(A_ADD, d); chk("R6", "sem after last dec", d, 0);
    rd(A_PTR, d); chk("R7", "pointer", d, 32'h2C0);
  endtask

  task automatic t_chain_end();
    logic [31:0] d;
    int s0 = scnt;
    put_pkt(32'h300, 32'h340, F_CH);
    put_pkt(32'h340, 32'h380, 32'h0);
    wr(A_PTR, 32'h300);
    wr(A_ADD, 32'd4);
    wait_quiet();
    repeat (60) @(negedge clk);
    chk("R8", "stop at chain end with sem 4", scnt - s0, 2);
    rd(A_ADD, d); chk("R8", "sem untouched", d, 4);
    rd(A_PTR, d); chk("R8", "pointer after end", d, 32'h380);
    wr(A_CLR, 32'hFF);
  endtask

  task automatic t_partial();
    logic [31:0] d;
    int s0 = scnt, f0;
    put_pkt(32'h400, 32'h440, F_CH | F_DEC);
    put_pkt(32'h440, 32'h480, F_CH | F_DEC);
    put_pkt(32'h480, 32'h4C0, F_CH | F_DEC);
    put_pkt(32'h4C0, 32'h500, F_DEC);
    wr(A_PTR, 32'h400);
    wr(A_ADD, 32'd2);
    wait_quiet();
    chk("R9", "halt after two packets", scnt - s0, 2);
    rd(A_PTR, d); chk("R9", "pointer on third packet", d, 32'h480);
    rd(A_ST, d);  chk("R9", "idle after halt", d, 0);
    f0 = fcnt;
    wr(A_ADD, 32'd5);
    wait_quiet();
    chk("R9", "resume runs remaining two", scnt - s0, 4);
    chk("R9", "resume fetch address", flog[f0], 32'h480);
    rd(A_ADD, d); chk("R9", "sem after resume", d, 3);
    wr(A_CLR, 32'hFF);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    int i0 = irq_cnt;
    put_pkt(32'h600, 32'h640, F_IE);
    put_pkt(32'h640, 32'h680, 32'h0);
    wr(A_PTR, 32'h600);
    wr(A_ADD, 32'd1);
    wait_quiet();
    chk("R12", "irq on enabled completion", irq_cnt - i0, 1);
    wr(A_CLR, 32'hFF);
    i0 = irq_cnt;
    wr(A_ADD, 32'd1);
    wait_quiet();
    rd(A_PTR, d); chk("R12", "second packet ran", d, 32'h680);
    chk("R12", "no irq when disabled", irq_cnt - i0, 0);
    wr(A_CLR, 32'hFF);
  endtask

  task automatic t_error();
    logic [31:0] d;
    int s0 = scnt, i0 = irq_cnt, f0;
    put_pkt(32'h700, 32'h740, F_CH | F_DEC);
    put_pkt(32'h740, 32'h780, F_CH | F_DEC);
    put_pkt(32'h780, 32'h7C0, F_DEC);
    err_idx = s0 + 1;
    wr(A_PTR, 32'h700);
    wr(A_ADD, 32'd5);
    wait_quiet();
    chk("R10", "stopped at failing packet", scnt - s0, 2);
    rd(A_ADD, d); chk("R10", "sem forced zero", d, 0);
    rd(A_ST, d);  chk("R13", "status error", d, 32'hD);
    chk("R10", "irq on error", irq_cnt - i0, 1);
    rd(A_PTR, d); chk("R10", "pointer on failing packet", d, 32'h740);
    err_idx = -1;
    wr(A_ADD, 32'd3);
    repeat (60) @(negedge clk);
    chk("R11", "no start while error pending", scnt - s0, 2);
    rd(A_ADD, d); chk("R11", "sem raised during error", d, 3);
    rd(A_ST, d);  chk("R11", "error stays set", d, 32'hD);
    f0 = fcnt;
    wr(A_ST, 32'h1);
    wait_quiet();
    rd(A_ST, d);  chk("R11", "error cleared", d, 0);
    chk("R11", "retry from pointer", flog[f0], 32'h740);
    chk("R11", "runs remaining packets", scnt - s0, 4);
    rd(A_ADD, d); chk("R11", "sem after retry", d, 1);
    rd(A_PTR, d); chk("R11", "pointer after retry", d, 32'h7C0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    err_idx = -1;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sem_regs();
    t_full_dec();
    t_last_dec();
    t_chain_end();
    t_partial();
    t_irq();
    t_error();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule